// File: doc/BRIEF.md
# Configurable GPIO Port with Polarity Inversion

This block implements one general-purpose I/O port of up to eight pins. Three byte registers control it: a direction register, a data register and an inversion register. They sit in a small register window whose base is chosen by a slot parameter. The port drives an output-enable and an output level for each pin toward a pad model. It samples the pad levels through a two-stage synchronizer and returns read data combinationally for the addressed register.

Three side inputs qualify the port. A port-enable bit and a two-bit pin-function select together gate all pad drive. A port-wide drive-mode bit picks either push-pull drive or open-drain drive, where only a low level is actively driven. Each pin's inversion bit complements both the level driven onto the pad and the level read back from it. A parameter reduces the number of implemented pins; the register bits and pads above that count do not exist.

Top module: `gpio_port`

## Requirements
- R1: After reset every implemented direction bit is 1 (input), every data and inversion bit is 0, and no pad output-enable is asserted.
- R2: The direction, data and inversion registers respond at base+0, base+1 and base+2, where base is 0xE0 for slot 0 and 0xE4 for slot 1. Writes to any other address change nothing, and reads of any other address return 0.
- R3: A direction bit of 1 makes its pin an input, so its output-enable stays low; a direction bit of 0 makes it an output.
- R4: In push-pull mode (drive-mode input 1), an active output pin asserts output-enable and drives the data bit XOR the inversion bit.
- R5: In open-drain mode (drive-mode input 0), an active output pin asserts output-enable with a low output only when the data bit XOR the inversion bit is 0. When that value is 1, output-enable is low.
- R6: With the port-enable input low, no output-enable is asserted.
- R7: Pads are driven only when the function select equals 2 (GPIO). The codes 0 (infrared off), 1 (infrared) and 3 (second serial port) leave every output-enable low.
- R8: For an input pin, the data register reads the synchronized pad level XOR the inversion bit. A pad change is first visible after the second rising clock edge that follows it.
- R9: For an output pin, the data register reads the stored data bit. The exception is an open-drain pin that is released (effective level 1), which reads the synchronized pad level XOR the inversion bit.
- R10: With a reduced pin count (for example 5), writes to the bits at and above the pin count are ignored, those bits read 0, and their output-enable and output level stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data for rd_addr |
| port_en | input | 1 | Port enable bit |
| drive_pp | input | 1 | Drive mode: 1 push-pull, 0 open-drain |
| func_sel | input | 2 | Pin function select; 2 selects GPIO |
| pad_in | input | DATA_W | Pad levels as seen at the pins |
| pad_oe | output | DATA_W | Per-pin output enable |
| pad_out | output | DATA_W | Per-pin driven level |

## Verification
A register write lands on the rising edge on which the strobe is sampled. The pad outputs and the read data follow combinationally within that same cycle. A pad change reaches the data register read only after two rising edges. The bench therefore drives every input on a falling edge and samples 1 ns later. It waits three full cycles after any change that alters pad levels before reading the data register. A dedicated sequence reads one cycle after a pad change and expects the old value, then reads again one cycle later and expects the new value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Pin function select codes
   typedef enum logic [1:0] {
      FSEL_IR_OFF = 2'd0,
      FSEL_IR     = 2'd1,
      FSEL_GPIO   = 2'd2,
      FSEL_SERIAL = 2'd3
   } fsel_e;

   // Register selected by an address
   typedef enum logic [1:0] {
      RSEL_DIR  = 2'd0,
      RSEL_DATA = 2'd1,
      RSEL_INV  = 2'd2,
      RSEL_NONE = 2'd3
   } rsel_e;

   localparam int SLOT_STRIDE = 4;
   localparam int SLOT0_BASE  = 'hE0;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
   import gpio_port_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PIN_COUNT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  rsel_e             wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] inv_q
);
   localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((64'd1 << PIN_COUNT) - 64'd1);

   logic [DATA_W-1:0] wr_masked;
   assign wr_masked = wr_data & IMPL_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= IMPL_MASK;
         data_q <= '0;
         inv_q  <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            RSEL_DIR:  dir_q  <= wr_masked;
            RSEL_DATA: data_q <= wr_masked;
            RSEL_INV:  inv_q  <= wr_masked;
            default:   ;
         endcase
      end
   end

   // A direction write lands the masked value on the next edge
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == RSEL_DIR) |=> (dir_q == ($past(wr_data) & IMPL_MASK))); // R2

   // A non-matching address leaves the inversion register unchanged
   AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == RSEL_NONE) |=> $stable(inv_q)); // R2

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int DATA_W    = 8,
   parameter int PIN_COUNT = 8,
   parameter int STAGES    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pad_in,
   output logic [DATA_W-1:0] sync_q
);
   localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((64'd1 << PIN_COUNT) - 64'd1);

   logic [DATA_W-1:0] raw_last;

   for (genvar i = 0; i < DATA_W; i++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], pad_in[i]};
      end
      assign raw_last[i] = chain[STAGES-1];
   end

   assign sync_q = raw_last & IMPL_MASK;

   // Elapsed-cycle counter so the delay check never looks before reset
   logic [1:0] warm_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              warm_cnt <= '0;
      else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
   end

   AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt >= 2'd2) |-> (sync_q == ($past(pad_in, 2) & IMPL_MASK))); // R8

endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive #(
   parameter int DATA_W    = 8,
   parameter int PIN_COUNT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              drive_pp,
   input  logic [DATA_W-1:0] dir_q,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] inv_q,
   output logic [DATA_W-1:0] pad_oe,
   output logic [DATA_W-1:0] pad_out,
   output logic [DATA_W-1:0] od_release
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_pin
      if (i < PIN_COUNT) begin : g_impl
         logic level;
         logic is_out;
         assign level         = data_q[i] ^ inv_q[i];
         assign is_out        = ~dir_q[i];
         assign pad_oe[i]     = active & is_out & (drive_pp | ~level);
         assign pad_out[i]    = pad_oe[i] & level;
         assign od_release[i] = is_out & ~drive_pp & level;
      end else begin : g_absent
         assign pad_oe[i]     = 1'b0;
         assign pad_out[i]    = 1'b0;
         assign od_release[i] = 1'b0;
      end
   end

   // A pin configured as input is never driven
   AST_INPUT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & dir_q) == '0); // R3

   // A released open-drain pin is never driven
   AST_RELEASE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & od_release) == '0); // R5

endmodule

// File: rtl/gpio_port_readback.sv
module gpio_port_readback
   import gpio_port_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  rsel_e             rd_sel,
   input  logic [DATA_W-1:0] dir_q,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] inv_q,
   input  logic [DATA_W-1:0] sync_q,
   input  logic [DATA_W-1:0] od_release,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] use_pin;
   logic [DATA_W-1:0] data_view;

   assign use_pin   = dir_q | od_release;
   assign data_view = (use_pin & (sync_q ^ inv_q)) | (~use_pin & data_q);

   always_comb begin
      case (rd_sel)
         RSEL_DIR:  rd_data = dir_q;
         RSEL_DATA: rd_data = data_view;
         RSEL_INV:  rd_data = inv_q;
         default:   rd_data = '0;
      endcase
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int PIN_COUNT = 8,
   parameter int SLOT      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              port_en,
   input  logic              drive_pp,
   input  logic [1:0]        func_sel,
   input  logic [DATA_W-1:0] pad_in,
   output logic [DATA_W-1:0] pad_oe,
   output logic [DATA_W-1:0] pad_out
);
   localparam int BASE_ADDR = SLOT0_BASE + SLOT_STRIDE * SLOT;
   localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'((64'd1 << PIN_COUNT) - 64'd1);

   // Elaboration-time parameter checks
   if (PIN_COUNT < 1 || PIN_COUNT > DATA_W) begin : g_bad_pins
      $error("gpio_port: PIN_COUNT out of range");
   end
   if (SLOT < 0 || SLOT > 1) begin : g_bad_slot
      $error("gpio_port: SLOT must be 0 or 1");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_port: ADDR_W must be at least 8");
   end

   function automatic rsel_e sel_of(input logic [ADDR_W-1:0] a);
      if (a == ADDR_W'(BASE_ADDR))     return RSEL_DIR;
      if (a == ADDR_W'(BASE_ADDR + 1)) return RSEL_DATA;
      if (a == ADDR_W'(BASE_ADDR + 2)) return RSEL_INV;
      return RSEL_NONE;
   endfunction

   rsel_e             wr_sel;
   rsel_e             rd_sel;
   logic              active;
   logic [DATA_W-1:0] dir_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] inv_q;
   logic [DATA_W-1:0] sync_q;
   logic [DATA_W-1:0] od_release;

   assign wr_sel = sel_of(wr_addr);
   assign rd_sel = sel_of(rd_addr);
   assign active = port_en && (func_sel == FSEL_GPIO);

   gpio_port_regs #(.DATA_W(DATA_W), .PIN_COUNT(PIN_COUNT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .dir_q   (dir_q),
      .data_q  (data_q),
      .inv_q   (inv_q)
   );

   gpio_port_sync #(.DATA_W(DATA_W), .PIN_COUNT(PIN_COUNT), .STAGES(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_in (pad_in),
      .sync_q (sync_q)
   );

   gpio_port_drive #(.DATA_W(DATA_W), .PIN_COUNT(PIN_COUNT)) u_drive (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .drive_pp   (drive_pp),
      .dir_q      (dir_q),
      .data_q     (data_q),
      .inv_q      (inv_q),
      .pad_oe     (pad_oe),
      .pad_out    (pad_out),
      .od_release (od_release)
   );

   gpio_port_readback #(.DATA_W(DATA_W)) u_read (
      .rd_sel     (rd_sel),
      .dir_q      (dir_q),
      .data_q     (data_q),
      .inv_q      (inv_q),
      .sync_q     (sync_q),
      .od_release (od_release),
      .rd_data    (rd_data)
   );

   // No drive while the port is disabled
   AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |-> (pad_oe == '0)); // R6

   // No drive while another pin function is selected
   AST_FUNC_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (func_sel != FSEL_GPIO) |-> (pad_oe == '0)); // R7

   // Open-drain never actively drives high
   AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_pp |-> ((pad_oe & pad_out) == '0)); // R5

   // A level appears only on a driven pin
   AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_out & ~pad_oe) == '0); // R4

   // Absent pins stay silent on the pads and on read data
   AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_out | rd_data) & ~IMPL_MASK) == '0); // R10

endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic       port_en = 1'b0;
   logic       drive_pp = 1'b0;
   logic [1:0] func_sel = 2'd0;
   logic [7:0] ext = '0;
   logic [7:0] rd0, rd1, oe0, out0, oe1, out1, pin0, pin1;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   assign pin0 = (oe0 & out0) | (~oe0 & ext);
   assign pin1 = (oe1 & out1) | (~oe1 & ext);

   gpio_port #(.PIN_COUNT(8), .SLOT(0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd0), .port_en(port_en), .drive_pp(drive_pp),
      .func_sel(func_sel), .pad_in(pin0), .pad_oe(oe0), .pad_out(out0));

   gpio_port #(.PIN_COUNT(5), .SLOT(1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd1), .port_en(port_en), .drive_pp(drive_pp),
      .func_sel(func_sel), .pad_in(pin1), .pad_oe(oe1), .pad_out(out1));

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d0, output logic [7:0] d1);
      rd_addr = a;
      #1;
      d0 = rd0;
      d1 = rd1;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] a0, a1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1 reset state
      rd(8'hE0, a0, a1); chk("R1 u0 dir", a0, 8'hFF);
      rd(8'hE4, a0, a1); chk("R1 u1 dir", a1, 8'h1F);
      rd(8'hE1, a0, a1); chk("R1 u0 data", a0, 8'h00);
      rd(8'hE2, a0, a1); chk("R1 u0 inv", a0, 8'h00);
      port_en = 1'b1; func_sel = 2'd2; drive_pp = 1'b1; #1;
      chk("R1 u0 oe", oe0, 8'h00);
      chk("R1 u1 oe", oe1, 8'h00);

      // R2 address map
      wr(8'hE2, 8'h3C);
      rd(8'hE2, a0, a1); chk("R2 u0 inv write", a0, 8'h3C);
      wr(8'hE3, 8'hFF);
      rd(8'hE2, a0, a1); chk("R2 stray addr keeps inv", a0, 8'h3C);
      rd(8'hE3, a0, a1); chk("R2 unmapped read", a0, 8'h00);
      wr(8'hE6, 8'h07);
      rd(8'hE2, a0, a1); chk("R2 u0 ignores slot1", a0, 8'h3C);
      rd(8'hE6, a0, a1); chk("R2 u1 inv at E6", a1, 8'h07);
      rd(8'hE2, a0, a1); chk("R2 u1 ignores slot0", a1, 8'h00);
      wr(8'hE6, 8'h00);

      // Drive sweep: R3 R4 R5 R6 R7 and read sweep: R8 R9
      for (int p = 0; p < 4; p++) begin
         logic [7:0] dv, dd, di, lvl;
         dv = 8'(p * 8'h47) ^ 8'h0F;
         dd = 8'(p * 8'h3B) ^ 8'hC3;
         di = 8'(p * 8'h29) ^ 8'h5A;
         lvl = dd ^ di;
         wr(8'hE0, dv); wr(8'hE1, dd); wr(8'hE2, di);
         for (int pp = 0; pp < 2; pp++) begin
            for (int en = 0; en < 2; en++) begin
               for (int fs = 0; fs < 4; fs++) begin
                  logic [7:0] eoe, eout;
                  @(negedge clk);
                  drive_pp = pp[0]; port_en = en[0]; func_sel = fs[1:0];
                  #1;
                  if (en == 1 && fs == 2)
                     eoe = ~dv & ((pp == 1) ? 8'hFF : ~lvl);
                  else
                     eoe = 8'h00;
                  eout = eoe & lvl;
                  if (en == 0) begin
                     chk("R6 oe disabled", oe0, eoe);
                  end else if (fs != 2) begin
                     chk("R7 oe other function", oe0, eoe);
                  end else if (pp == 1) begin
                     chk("R3,R4 oe push-pull", oe0, eoe);
                     chk("R4 out push-pull", out0, eout);
                  end else begin
                     chk("R3,R5 oe open-drain", oe0, eoe);
                     chk("R5 out open-drain", out0, eout);
                  end
               end
            end
            for (int e = 0; e < 2; e++) begin
               logic [7:0] rel, usep, erd;
               @(negedge clk);
               port_en = 1'b1; func_sel = 2'd2; drive_pp = pp[0];
               ext = (e == 0) ? 8'h96 : 8'h69;
               settle();
               rel = ~dv & ((pp == 1) ? 8'h00 : lvl);
               usep = dv | rel;
               erd = (usep & (ext ^ di)) | (~usep & dd);
               rd(8'hE1, a0, a1);
               if (pp == 1) chk("R8,R9 data read push-pull", a0, erd);
               else         chk("R8,R9 data read open-drain", a0, erd);
            end
         end
      end

      // R8 two-edge visibility
      wr(8'hE0, 8'hFF); wr(8'hE2, 8'h0F);
      @(negedge clk); ext = 8'h00;
      settle();
      ext = 8'hA5;
      @(negedge clk);
      rd(8'hE1, a0, a1); chk("R8 one edge still old", a0, 8'h0F);
      @(negedge clk);
      rd(8'hE1, a0, a1); chk("R8 two edges new", a0, 8'hAA);

      // R10 reduced pin count
      port_en = 1'b1; func_sel = 2'd2; drive_pp = 1'b1;
      wr(8'hE6, 8'h00); wr(8'hE5, 8'hFF); wr(8'hE4, 8'h00);
      #1;
      chk("R10 u1 oe upper absent", oe1, 8'h1F);
      chk("R10 u1 out upper absent", out1, 8'h1F);
      rd(8'hE5, a0, a1); chk("R10 u1 data upper reads 0", a1, 8'h1F);
      wr(8'hE4, 8'hE0);
      rd(8'hE4, a0, a1); chk("R10 u1 dir upper write ignored", a1, 8'h00);
      rd(8'hE0, a0, a1); chk("R2 u0 dir untouched by slot1", a0, 8'hFF);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule